// File: doc/BRIEF.md
# Data Cache Set Tag Validator

This block checks the stored tags of one data cache set, one way per clock, after a start pulse. For each way it decodes the 5-bit coherence state held in the tag-high word. It also checks the two parity bits that guard the physical address tag, and it rebuilds the physical line address from the tag-low word and the set index.

The block steps through the ways itself. It drives `way_sel`, and the surrounding logic returns that way's tag-high and tag-low words on the same cycle. A registered result appears one cycle later. Tag-state and tag-address errors are collected across the whole set, and `done` rises together with the result of the last way. The bank and set-within-bank numbers taken from the captured index are also provided, for error reporting.

Top module: `dc_tag_check`

## Requirements
- R1: The coherence state is tag_hi bits 29..25. It is reported on res_class as: 0x00 → 0 (invalid), 0x0F → 1 (coherent shared), 0x13 → 2 (non-coherent exclusive clean), 0x19 → 3 (non-coherent exclusive dirty), 0x16 → 4 (coherent exclusive clean), 0x1C → 5 (coherent exclusive dirty).
- R2: Any other state encoding gives res_class 7 and sets res_state_err. The parity checks for that way are skipped, so res_addr_err stays 0.
- R3: For a legal state, res_addr_err is set when tag_lo bit 11 differs from the XOR of tag_lo bits 39..26.
- R4: For a legal state, res_addr_err is set when tag_lo bit 10 differs from the XOR of tag_lo bits 25..13.
- R5: res_addr equals tag_lo bits 39..13 placed above the 13-bit set index captured at start.
- R6: bank is {index bit 12, index bit 5} and set_no is index bits 11..6, both taken from the captured index.
- R7: A start accepted while idle raises busy at the next edge with way_sel = 0. Each following edge samples way way_sel, presents its result on res_valid/res_way one cycle later, and advances way_sel by one. busy falls after way 3 is sampled.
- R8: err_state and err_addr are the OR of the per-way flags of the current pass. They are cleared when a start is accepted. done pulses for one cycle together with the result of way 3.
- R9: A start while busy is ignored: the way sequence, the captured index and the collected flags continue unchanged.
- R10: After reset the block is idle, with busy, res_valid, done, err_state and err_addr all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass over the set |
| set_idx | input | 13 | Set index, captured at start |
| way_sel | output | 2 | Way whose tags are requested this cycle |
| tag_hi | input | 32 | Tag-high word of way way_sel |
| tag_lo | input | 64 | Tag-low word of way way_sel |
| busy | output | 1 | Pass in progress |
| res_valid | output | 1 | Per-way result valid |
| res_way | output | 2 | Way the result belongs to |
| res_class | output | 3 | Decoded state class (7 = illegal) |
| res_addr | output | 40 | Rebuilt physical line address |
| res_state_err | output | 1 | Illegal state in this way |
| res_addr_err | output | 1 | Address tag parity error in this way |
| done | output | 1 | Last way's result is on the outputs |
| err_state | output | 1 | Collected tag-state error |
| err_addr | output | 1 | Collected tag-address error |
| bank | output | 2 | Bank number from captured index |
| set_no | output | 6 | Set number within bank from captured index |

## Verification
The bench sends every legal state and two illegal ones, with each parity bit corrupted alone and both corrupted together. A design that checked parity on an illegal state would report a spurious address error. A design with a wrong range boundary would miss or invent a parity error, because the tag words vary from vector to vector. The invalid state carries a corrupted parity bit, so a design that treated "invalid" as "not checked" would miss that error. A second start during a pass, with the index input changed, exposes a design that restarts, clears its collected flags, or recaptures the index. A clean pass after an erroneous one shows whether the collected flags are cleared at start.

// File: rtl/dc_tag_check.sv
module dc_tag_check #(
  parameter int WAYS   = 4,
  parameter int PA_W   = 40,
  parameter int IDX_W  = 13,
  parameter int SPLIT  = 26,
  parameter int ST_LSB = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [IDX_W-1:0]          set_idx,
  output logic [$clog2(WAYS)-1:0]   way_sel,
  input  logic [31:0]               tag_hi,
  input  logic [63:0]               tag_lo,
  output logic                      busy,
  output logic                      res_valid,
  output logic [$clog2(WAYS)-1:0]   res_way,
  output logic [2:0]                res_class,
  output logic [PA_W-1:0]           res_addr,
  output logic                      res_state_err,
  output logic                      res_addr_err,
  output logic                      done,
  output logic                      err_state,
  output logic                      err_addr,
  output logic [1:0]                bank,
  output logic [5:0]                set_no
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int ST_W   = 5;
  localparam int PHI    = 11;
  localparam int PLO    = 10;
  localparam logic [2:0] C_BAD = 3'd7;

  logic [WAY_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic [ST_W-1:0]  st;
  logic [2:0]       cls;
  logic             illegal, perr_hi, perr_lo, perr;
  logic             unused_bits;

  assign way_sel = cnt;
  assign st      = tag_hi[ST_LSB +: ST_W];

  always_comb begin
    case (st)
      5'h00:   cls = 3'd0;
      5'h0F:   cls = 3'd1;
      5'h13:   cls = 3'd2;
      5'h19:   cls = 3'd3;
      5'h16:   cls = 3'd4;
      5'h1C:   cls = 3'd5;
      default: cls = C_BAD;
    endcase
  end

  assign illegal = (cls == C_BAD);
  assign perr_hi = tag_lo[PHI] ^ (^tag_lo[PA_W-1:SPLIT]);
  assign perr_lo = tag_lo[PLO] ^ (^tag_lo[SPLIT-1:IDX_W]);
  assign perr    = !illegal && (perr_hi || perr_lo);

  assign bank   = {idx_q[12], idx_q[5]};
  assign set_no = idx_q[11:6];

  assign unused_bits = ^{tag_hi[31:ST_LSB+ST_W], tag_hi[ST_LSB-1:0],
                         tag_lo[63:PA_W], tag_lo[IDX_W-1:PHI+1], tag_lo[PLO-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      cnt           <= '0;
      idx_q         <= '0;
      res_valid     <= 1'b0;
      res_way       <= '0;
      res_class     <= 3'd0;
      res_addr      <= '0;
      res_state_err <= 1'b0;
      res_addr_err  <= 1'b0;
      done          <= 1'b0;
      err_state     <= 1'b0;
      err_addr      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        cnt       <= '0;
        idx_q     <= set_idx;
        err_state <= 1'b0;
        err_addr  <= 1'b0;
      end else if (busy) begin
        res_valid     <= 1'b1;
        res_way       <= cnt;
        res_class     <= cls;
        res_addr      <= {tag_lo[PA_W-1:IDX_W], idx_q};
        res_state_err <= illegal;
        res_addr_err  <= perr;
        err_state     <= err_state | illegal;
        err_addr      <= err_addr | perr;
        cnt           <= cnt + 1'b1;
        if (cnt == WAY_W'(WAYS-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module dc_tag_check_props #(
  parameter int WAYS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [$clog2(WAYS)-1:0] way_sel,
  input logic                    busy,
  input logic                    res_valid,
  input logic [$clog2(WAYS)-1:0] res_way,
  input logic [2:0]              res_class,
  input logic                    res_state_err,
  input logic                    res_addr_err,
  input logic                    done,
  input logic                    err_state,
  input logic                    err_addr
);
  localparam int WAY_W = $clog2(WAYS);

  p_illegal_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_class == 3'd7 |-> res_state_err && !res_addr_err);

  p_state_err_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_state_err |-> res_class == 3'd7);

  p_way_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && way_sel != WAY_W'(WAYS-1) |=> busy && way_sel == $past(way_sel) + 1'b1);

  p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> res_valid && res_way == $past(way_sel));

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid && res_way == WAY_W'(WAYS-1) && !busy);

  p_collect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (err_state || !res_state_err) && (err_addr || !res_addr_err));
endmodule

bind dc_tag_check dc_tag_check_props #(.WAYS(WAYS)) u_props (
  .clk(clk), .rst_n(rst_n), .way_sel(way_sel), .busy(busy),
  .res_valid(res_valid), .res_way(res_way), .res_class(res_class),
  .res_state_err(res_state_err), .res_addr_err(res_addr_err),
  .done(done), .err_state(err_state), .err_addr(err_addr)
);

// File: tb/dc_tag_check_test.sv
`timescale 1ns/1ps
module dc_tag_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] set_idx = '0;
  logic [1:0]  way_sel;
  logic [31:0] tag_hi;
  logic [63:0] tag_lo;
  logic        busy, res_valid, res_state_err, res_addr_err, done, err_state, err_addr;
  logic [1:0]  res_way, bank;
  logic [2:0]  res_class;
  logic [39:0] res_addr;
  logic [5:0]  set_no;

  logic [31:0] th [4];
  logic [63:0] tl [4];
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign tag_hi = th[way_sel];
  assign tag_lo = tl[way_sel];

  dc_tag_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .set_idx(set_idx), .way_sel(way_sel),
    .tag_hi(tag_hi), .tag_lo(tag_lo), .busy(busy), .res_valid(res_valid),
    .res_way(res_way), .res_class(res_class), .res_addr(res_addr),
    .res_state_err(res_state_err), .res_addr_err(res_addr_err), .done(done),
    .err_state(err_state), .err_addr(err_addr), .bank(bank), .set_no(set_no)
  );

  // state, corrupt bit 11, corrupt bit 10, expected class
  localparam logic [9:0] VEC [12] = '{
    {5'h00, 1'b0, 1'b0, 3'd0}, {5'h0F, 1'b0, 1'b0, 3'd1},
    {5'h13, 1'b0, 1'b0, 3'd2}, {5'h19, 1'b0, 1'b0, 3'd3},
    {5'h16, 1'b0, 1'b0, 3'd4}, {5'h1C, 1'b0, 1'b0, 3'd5},
    {5'h01, 1'b0, 1'b0, 3'd7}, {5'h13, 1'b1, 1'b0, 3'd2},
    {5'h1F, 1'b1, 1'b1, 3'd7}, {5'h1C, 1'b0, 1'b1, 3'd5},
    {5'h0F, 1'b1, 1'b1, 3'd1}, {5'h00, 1'b1, 1'b0, 3'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_group(input int g, input logic [12:0] ix, input bit restart);
    bit es = 0, ea = 0;
    for (int w = 0; w < 4; w++) begin
      logic [9:0]  v = VEC[g*4+w];
      logic [63:0] lo = 64'h9E3779B97F4A7C15 * 64'(g*4+w+1);
      lo[11] = (^lo[39:26]) ^ v[4];
      lo[10] = (^lo[25:13]) ^ v[3];
      tl[w] = lo;
      th[w] = (32'hC3F05A5A & ~32'h3E000000) | ({27'd0, v[9:5]} << 25);
    end
    @(negedge clk);
    set_idx = ix;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    set_idx = ~ix;
    check("R7 busy after start", busy, 1);
    check("R7 first way", way_sel, 0);
    for (int w = 0; w < 4; w++) begin
      logic [9:0] v = VEC[g*4+w];
      bit se = (v[2:0] == 3'd7);
      bit ae = !se && (v[4] || v[3]);
      if (restart && w == 1) start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      es |= se; ea |= ae;
      check("R7 res_valid", res_valid, 1);
      check(restart ? "R9 way order" : "R7 way order", res_way, w);
      check(se ? "R2 class" : "R1 class", res_class, v[2:0]);
      check("R2 state err", res_state_err, se);
      check(v[4] ? "R3 addr err" : "R4 addr err", res_addr_err, ae);
      check(restart ? "R9 addr" : "R5 addr", res_addr, {tl[w][39:13], ix});
      check("R8 done", done, w == 3);
      check("R6 bank", bank, {ix[12], ix[5]});
      check("R6 set", set_no, ix[11:6]);
    end
    check(restart ? "R9 err_state" : "R8 err_state", err_state, es);
    check(restart ? "R9 err_addr" : "R8 err_addr", err_addr, ea);
    @(posedge clk); #1;
    check("R8 done pulse", done, 0);
    check("R7 idle", busy, 0);
    check("R7 no result", res_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) begin th[w] = '0; tl[w] = '0; end
    #12;
    check("R10 busy", busy, 0);
    check("R10 valid", res_valid, 0);
    check("R10 done", done, 0);
    check("R10 err", {err_state, err_addr}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 idle after release", busy, 0);
    run_group(0, 13'h1FE0, 0);
    run_group(1, 13'h1021, 0);
    run_group(2, 13'h0FC1, 1);
    run_group(0, 13'h0A6E, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule